// File: doc/BRIEF.md
# Streaming 8-Point Hartley Transform

This block computes the one-dimensional discrete Hartley transform of eight signed samples, H(k) = sum over n of x(n)·(cos(2πnk/8) + sin(2πnk/8)). Samples enter one at a time, each qualified by a strobe. Cycles without the strobe are skipped. Every eight accepted samples form one frame. The frame is handed in parallel to a pipelined radix-2 butterfly network. That network has two add/subtract stages for the two interleaved 4-point transforms, a stage that forms the inputs of the rotation, a registered constant multiply by √2/2, and a final add/subtract stage. The eight results then leave the block one per clock, with their own strobe.

The sample width is the parameter N. The result is N+3 bits wide, which is the growth that an eight-term sum with unit-magnitude weights needs. Frames may follow one another with no idle cycle between them. Their results then leave as one unbroken stream.

Top module: `hartley8_stream`

## Requirements
- R1: A sample is taken only on a clock where `in_valid` is 1. Cycles with `in_valid` at 0 are ignored, whatever `in_data` carries, and may fall anywhere inside a frame. The sample taken n-th in a frame (n = 0..7) is x(n).
- R2: For each frame the block gives eight results in the order k = 0, 1, …, 7 on eight consecutive cycles with `out_valid` at 1. The even-index results equal the exact transform.
- R3: Odd-index results use the √2/2 constant, held with N+4 fractional bits and rounded to nearest. Each is within one unit of the exact transform value.
- R4: The result for k = 0 is registered at the sixth rising edge after the edge that takes the frame's last sample.
- R5: Frames sent back to back, with no idle cycle between them, are all transformed, and their results leave without a gap.
- R6: Both full-scale inputs fit the N+3-bit two's-complement output without wrapping: all −2^(N−1) gives H(0) = −2^(N+2), and all 2^(N−1)−1 gives H(0) = 8·(2^(N−1)−1).
- R7: A synchronous active-high `rst` drops `out_valid` on the next edge and discards a partly collected frame. The first eight samples after reset form a complete new frame.
- R8: While `out_valid` is 0, `out_data` keeps its last value.
- R9: `out_valid` is never 1 unless a complete frame was taken in. Each frame yields exactly eight results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_data` on this clock |
| in_data | input | N | Input sample, two's complement |
| out_valid | output | 1 | Qualifies `out_data` on this clock |
| out_data | output | N+3 | Transform result H(k), two's complement, k ascending |

## Verification
On every cycle the assertions check the following:
- the fixed distance from a frame's last sample to its first result;
- that every output burst is a whole multiple of eight results;
- that no result appears without a collected frame;
- that the output word holds between bursts;
- that reset silences the output.

Only the bench's scenarios can show whether the numbers are right. These scenarios are impulses, a ramp, alternating extremes, both full-scale frames, frames broken up by idle cycles, and a frame that follows a reset landing mid-frame. Only they show that the frame boundary restarts cleanly after that reset.

// File: rtl/hartley8_pkg.sv
package hartley8_pkg;

  localparam int PTS  = 8;
  localparam int IDXW = $clog2(PTS);

  // round(sqrt(2)/2 * 2^frac) = round(sqrt(2^(2*frac-1)))
  function automatic longint unsigned round_half_root2(input int frac);
    longint unsigned v;
    longint unsigned s;
    longint unsigned t;
    v = longint'(1) << (2 * frac - 1);
    s = 0;
    for (int b = 31; b >= 0; b--) begin
      t = s | (longint'(1) << b);
      if (t * t <= v) s = t;
    end
    if (s * s + s < v) s = s + 1;
    return s;
  endfunction

endpackage

// File: rtl/hartley8_gather.sv
module hartley8_gather import hartley8_pkg::*; #(
  parameter int N = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [N-1:0]        in_data,
  output logic                frame_vld,
  output logic signed [N-1:0] frame [PTS]
);

  localparam logic [IDXW-1:0] LAST = IDXW'(PTS - 1);

  logic [IDXW-1:0] cnt;
  logic [N-1:0]    hist [PTS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      frame_vld <= 1'b0;
    end else begin
      frame_vld <= in_valid && (cnt == LAST);
      if (in_valid) cnt <= cnt + 1'b1;
    end
  end

  // shift register: oldest sample sits at index 0 once seven are held
  always_ff @(posedge clk) begin
    if (in_valid) begin
      for (int i = 0; i < PTS - 2; i++) hist[i] <= hist[i+1];
      hist[PTS-2] <= in_data;
    end
  end

  // aligner: whole frame presented in parallel, registered
  always_ff @(posedge clk) begin
    if (in_valid && (cnt == LAST)) begin
      for (int i = 0; i < PTS - 1; i++) frame[i] <= $signed(hist[i]);
      frame[PTS-1] <= $signed(in_data);
    end
  end

endmodule

// File: rtl/hartley8_rotmul.sv
module hartley8_rotmul import hartley8_pkg::*; #(
  parameter int W    = 11,
  parameter int FRAC = 12
) (
  input  logic                clk,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);

  localparam longint unsigned CST = round_half_root2(FRAC);
  localparam int PW = W + FRAC + 2;
  localparam logic signed [PW-1:0] KMUL = PW'(CST);
  localparam logic signed [PW-1:0] HALF = PW'(longint'(1) << (FRAC - 1));

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;

  assign prod = PW'(din) * KMUL;
  assign rnd  = prod + HALF;

  always_ff @(posedge clk) dout <= W'(rnd >>> FRAC);

endmodule

// File: rtl/hartley8_butterfly.sv
module hartley8_butterfly import hartley8_pkg::*; #(
  parameter int N    = 8,
  parameter int W    = N + 3,
  parameter int FRAC = N + 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_vld,
  input  logic signed [N-1:0] frame [PTS],
  output logic                mid_vld,
  output logic signed [W-1:0] even_q [4],
  output logic signed [W-1:0] odd0_q,
  output logic signed [W-1:0] odd2_q,
  output logic signed [W-1:0] rot_q [2]
);

  logic v1, v2, v3;
  logic signed [W-1:0] st1 [2][4];
  logic signed [W-1:0] st2 [2][4];
  logic signed [W-1:0] ev3 [4];
  logic signed [W-1:0] o0_3, o2_3;
  logic signed [W-1:0] mul_in [2];

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0; mid_vld <= 1'b0;
    end else begin
      v1 <= frame_vld; v2 <= v1; v3 <= v2; mid_vld <= v3;
    end
  end

  // half g = 0 takes even samples, g = 1 odd samples: y(i) = x(2i+g)
  always_ff @(posedge clk) begin
    for (int g = 0; g < 2; g++) begin
      st1[g][0] <= W'(frame[g])   + W'(frame[g+4]);
      st1[g][1] <= W'(frame[g])   - W'(frame[g+4]);
      st1[g][2] <= W'(frame[g+2]) + W'(frame[g+6]);
      st1[g][3] <= W'(frame[g+2]) - W'(frame[g+6]);
      st2[g][0] <= st1[g][0] + st1[g][2];
      st2[g][2] <= st1[g][0] - st1[g][2];
      st2[g][1] <= st1[g][1] + st1[g][3];
      st2[g][3] <= st1[g][1] - st1[g][3];
    end
  end

  // stage 3: registered multiplier inputs, even terms ride along
  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) ev3[i] <= st2[0][i];
    o0_3      <= st2[1][0];
    o2_3      <= st2[1][2];
    mul_in[0] <= st2[1][1] + st2[1][3];
    mul_in[1] <= st2[1][1] - st2[1][3];
  end

  // stage 4: delay the pass-through terms to meet the products
  always_ff @(posedge clk) begin
    for (int i = 0; i < 4; i++) even_q[i] <= ev3[i];
    odd0_q <= o0_3;
    odd2_q <= o2_3;
  end

  for (genvar m = 0; m < 2; m++) begin : g_rot
    hartley8_rotmul #(.W(W), .FRAC(FRAC)) u_rot (
      .clk  (clk),
      .din  (mul_in[m]),
      .dout (rot_q[m])
    );
  end

endmodule

// File: rtl/hartley8_unload.sv
module hartley8_unload import hartley8_pkg::*; #(
  parameter int W = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mid_vld,
  input  logic signed [W-1:0] even_q [4],
  input  logic signed [W-1:0] odd0_q,
  input  logic signed [W-1:0] odd2_q,
  input  logic signed [W-1:0] rot_q [2],
  output logic                out_valid,
  output logic [W-1:0]        out_data
);

  localparam logic [IDXW-1:0] LAST = IDXW'(PTS - 1);

  logic signed [W-1:0] obuf [PTS];
  logic [IDXW-1:0]     idx;
  logic                act;

  // final butterfly, written in output index order
  always_ff @(posedge clk) begin
    if (mid_vld) begin
      obuf[0] <= even_q[0] + odd0_q;
      obuf[1] <= even_q[1] + rot_q[0];
      obuf[2] <= even_q[2] + odd2_q;
      obuf[3] <= even_q[3] + rot_q[1];
      obuf[4] <= even_q[0] - odd0_q;
      obuf[5] <= even_q[1] - rot_q[0];
      obuf[6] <= even_q[2] - odd2_q;
      obuf[7] <= even_q[3] - rot_q[1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act       <= 1'b0;
      idx       <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= act;
      if (act) begin
        out_data <= obuf[idx];
        idx      <= idx + 1'b1;
        if (idx == LAST) act <= 1'b0;
      end
      if (mid_vld) begin
        act <= 1'b1;
        idx <= '0;
      end
    end
  end

endmodule

// File: rtl/hartley8_stream.sv
module hartley8_stream import hartley8_pkg::*; #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N-1:0]   in_data,
  output logic           out_valid,
  output logic [N+2:0]   out_data
);

  localparam int W    = N + 3;
  localparam int FRAC = N + 4;

  logic                frame_vld;
  logic signed [N-1:0] frame [PTS];
  logic                mid_vld;
  logic signed [W-1:0] even_q [4];
  logic signed [W-1:0] odd0_q, odd2_q;
  logic signed [W-1:0] rot_q [2];

  hartley8_gather #(.N(N)) u_gather (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .frame_vld (frame_vld),
    .frame     (frame)
  );

  hartley8_butterfly #(.N(N), .W(W), .FRAC(FRAC)) u_bfly (
    .clk       (clk),
    .rst       (rst),
    .frame_vld (frame_vld),
    .frame     (frame),
    .mid_vld   (mid_vld),
    .even_q    (even_q),
    .odd0_q    (odd0_q),
    .odd2_q    (odd2_q),
    .rot_q     (rot_q)
  );

  hartley8_unload #(.W(W)) u_unload (
    .clk       (clk),
    .rst       (rst),
    .mid_vld   (mid_vld),
    .even_q    (even_q),
    .odd0_q    (odd0_q),
    .odd2_q    (odd2_q),
    .rot_q     (rot_q),
    .out_valid (out_valid),
    .out_data  (out_data)
  );

endmodule

// File: rtl/hartley8_stream_chk.sv
module hartley8_stream_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         out_valid,
  input logic [N+2:0] out_data
);

  logic [2:0] taken;
  logic [2:0] run;
  logic [4:0] pending;
  logic       done;

  assign done = in_valid && (taken == 3'd7);

  always_ff @(posedge clk) begin
    if (rst) begin
      taken   <= '0;
      run     <= '0;
      pending <= '0;
    end else begin
      if (in_valid)  taken <= taken + 1'b1;
      if (out_valid) run   <= run + 1'b1;
      pending <= pending + (done ? 5'd8 : 5'd0) - (out_valid ? 5'd1 : 5'd0);
    end
  end

  assert_reset_quiet_R7: assert property (@(posedge clk)
    rst |=> !out_valid);

  assert_fixed_latency_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> ##7 out_valid);

  assert_whole_bursts_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(out_valid) |-> (run == 3'd0));

  assert_no_orphan_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (pending != 5'd0));

  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst)) |-> $stable(out_data));

endmodule

bind hartley8_stream hartley8_stream_chk #(.N(N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_data  (out_data)
);

// File: tb/hartley8_stream_test.sv
`timescale 1ns/1ps
module hartley8_stream_test;

  localparam int N   = 8;
  localparam int W   = N + 3;
  localparam int PTS = 8;
  localparam int NV  = 8;
  localparam real PI = 3.14159265358979323846;

  // sample n sits in bits [n*N +: N]
  localparam logic [PTS*N-1:0] VEC [NV] = '{
    64'h0000000000000001,
    64'h0000000000006400,
    64'h0706050403020100,
    64'h7F7F7F7F7F7F7F7F,
    64'h8080808080808080,
    64'h817F817F817F817F,
    64'h9C3A05E2147FC880,
    64'h80817F7F8081807F
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [N-1:0] in_data = '0;
  logic out_valid;
  logic [W-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int nfr    = 0;
  int ofr    = 0;
  int ok     = 0;
  int nout   = 0;
  int    fr_mem   [32][PTS];
  int    cap_last [32];
  string tag      [32];

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  hartley8_stream #(.N(N)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic real ref_h(input int f, input int k);
    real s = 0.0;
    for (int n = 0; n < PTS; n++) begin
      real a = 2.0 * PI * n * k / PTS;
      s += fr_mem[f][n] * ($cos(a) + $sin(a));
    end
    return s;
  endfunction

  function automatic int iround(input real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  always @(negedge clk) begin : mon
    real r;
    int  got;
    if (!rst && out_valid) begin
      r   = ref_h(ofr, ok);
      got = int'($signed(out_data));
      if (ok % 2 == 0)
        chk(got == iround(r), $sformatf("%s k=%0d", tag[ofr], ok), got, iround(r));
      else
        chk(((got - r) < 1.0) && ((r - got) < 1.0),
            $sformatf("R3 %s k=%0d", tag[ofr], ok), got, iround(r));
      if (ok == 0)
        chk(cyc == cap_last[ofr] + 6, "R4 latency", cyc - cap_last[ofr], 6);
      nout++;
      ok++;
      if (ok == PTS) begin
        ok = 0;
        ofr++;
      end
    end
  end

  task automatic send_frame(input logic [PTS*N-1:0] v, input int gap, input string t);
    for (int j = 0; j < PTS; j++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = v[j*N +: N];
      fr_mem[nfr][j] = int'($signed(v[j*N +: N]));
      if (j == PTS - 1) begin
        cap_last[nfr] = cyc + 1;
        tag[nfr] = t;
        nfr++;
      end else begin
        for (int i = 0; i < gap; i++) begin
          @(negedge clk);
          in_valid = 1'b0;
          in_data  = 8'hA5;
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = 8'h5A;
    end
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    summary();
  end

  initial begin : main
    logic [W-1:0] held;
    // R7: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R7 reset out_valid", int'(out_valid), 0);
    rst = 1'b0;

    // vector table, back to back (R5); full-scale frames tagged R6
    for (int v = 0; v < NV; v++)
      send_frame(VEC[v], 0, (v == 3 || v == 4) ? "R6" : "R5");
    idle(20);

    // R1: idle cycles with junk data inside a frame
    send_frame(64'h11F0_7E83_0C22_D419, 2, "R1");
    send_frame(64'h0102_0408_1020_4080, 1, "R1");
    idle(20);

    // R7: reset during a partial frame, then a clean frame
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'h77;
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_valid == 1'b0, "R7 out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    send_frame(64'h0000000000000003, 0, "R7");
    idle(20);

    // R8 and R1: junk on in_data with in_valid low changes nothing
    held = out_data;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_data  = N'(i * 37);
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 idle out_valid", int'(out_valid), 0);
      chk(out_data == held, "R8 hold", int'(out_data), int'(held));
    end

    // R9: exactly eight results per frame, none extra
    chk(nout == nfr * PTS, "R9 result count", nout, nfr * PTS);
    summary();
  end

endmodule